// File: doc/BRIEF.md
# Complementary Gate-Drive Dead-Band Generator

This block turns a single raw PWM waveform into a high-side and a low-side gate-drive signal that are never on together. At every transition of the raw waveform the output that must turn off does so on the next clock. The output that must turn on stays off until a down-counter has run out. The counter's start value and the rate at which it counts are programmed through a small write port that carries a 6-bit count and a 2-bit rate select.

The counter does not count on every clock. The chip's instruction cycle has four phases, and the block is given the current phase and the phase on which the duty-cycle compare last matched. A flag says whether the PWM time base runs at full rate. Together with the rate select, these inputs pick the phases on which the counter may advance. A small prescaler then divides those qualified phases further. The prescaler restarts whenever the counter reloads and whenever the configuration is written, so an interval always begins on a clean prescale boundary.

Top module: `dt_insert`

## Requirements
- R1: While reset is held, and after it is released, both gate outputs are low. The stored count and rate select are both zero.
- R2: A write (`cfg_we` high at a clock edge) stores `cfg_count` and `cfg_psel`. The rate select `cfg_psel` is encoded as 00 = divide-by-2 rate, 01 = divide-by-4, 10 = divide-by-8, 11 = divide-by-16.
- R3: A change of `pwm_in` sampled at a clock edge reloads the counter with the stored count. On a rise, `gate_lo` is low after that same edge and `gate_hi` goes high only when the counter reaches zero. A fall behaves the same way with the roles of the two outputs swapped.
- R4: `gate_hi` and `gate_lo` are never high in the same cycle.
- R5: With a stored count of zero, the output being turned on changes at the same edge as the output being turned off, so no gap is inserted.
- R6: With `base_fast` low, selects 01, 10 and 11 count only on phase 0 (Q1). Select 00 counts on phases 0 and 2 (Q1 and Q3).
- R7: With `base_fast` high and select 00, the counter counts on the two phases whose bit 0 equals bit 0 of `match_phase`: Q1/Q3 for a match on phase 0 or 2, and Q2/Q4 for a match on phase 1 or 3.
- R8: With `base_fast` high and select 01, 10 or 11, the counter counts only on the phase equal to `match_phase`.
- R9: One decrement needs 1, 1, 2 or 4 qualified phases for selects 00, 01, 10 and 11 respectively.
- R10: The prescaler is cleared by a counter reload and by a configuration write. A qualified phase in the same cycle as the clear is not counted.
- R11: An edge of `pwm_in` that arrives while an interval is running restarts the interval for the new direction. The output of the abandoned direction never turns on.
- R12: The largest count, 63, at the slowest rate produces the full delay of 63 decrements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_count | input | 6 | Dead-time count to store |
| cfg_psel | input | 2 | Counting-rate select to store |
| phase | input | 2 | Current instruction-cycle phase, 0..3 for Q1..Q4 |
| match_phase | input | 2 | Phase on which the duty compare matched |
| base_fast | input | 1 | High when the PWM time base runs at 1:1 |
| pwm_in | input | 1 | Raw PWM waveform |
| gate_hi | output | 1 | High-side drive |
| gate_lo | output | 1 | Low-side drive |

## Verification
A prescaler that is not cleared, or a phase that is qualified wrongly, shows up only as a dead band that is too short or too long. The first visible symptom is therefore the cycle in which the delayed output turns on. The bench predicts that exact cycle from the phase at the edge and compares it against the cycle it observes. A lost reload or a mistracked direction shows up at once as overlapping outputs or as the wrong output turning on, and the first clock after the offending edge already reveals it.

// File: rtl/dt_pkg.sv
package dt_pkg;
  localparam int PH_W  = 2;
  localparam int PRE_W = 2;

  typedef enum logic [1:0] {
    RATE_D2  = 2'b00,
    RATE_D4  = 2'b01,
    RATE_D8  = 2'b10,
    RATE_D16 = 2'b11
  } rate_e;

  // last prescaler value before a decrement is released
  function automatic logic [PRE_W-1:0] pre_last(input rate_e r);
    case (r)
      RATE_D8:  pre_last = PRE_W'(1);
      RATE_D16: pre_last = PRE_W'(3);
      default:  pre_last = PRE_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/dt_rst_sync.sv
module dt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/dt_cfg_reg.sv
module dt_cfg_reg
  import dt_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic [1:0]       rate_in,
  output logic [CNT_W-1:0] cnt_q,
  output rate_e            rate_q
);
  logic [CNT_W-1:0] cnt_d;
  rate_e            rate_d;

  always_comb begin
    cnt_d  = cnt_q;
    rate_d = rate_q;
    if (we) begin
      cnt_d  = cnt_in;
      rate_d = rate_e'(rate_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rate_q <= RATE_D2;
    end else begin
      cnt_q  <= cnt_d;
      rate_q <= rate_d;
    end
  end
endmodule

// File: rtl/dt_tick_gen.sv
module dt_tick_gen
  import dt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  phase,
  input  logic [PH_W-1:0]  match_phase,
  input  logic             base_fast,
  input  rate_e            rate,
  input  logic             clr,
  output logic             tick,
  output logic [PRE_W-1:0] pre_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic             qual;
  logic             wrap;

  // phase qualification
  always_comb begin
    if (!base_fast) begin
      if (rate == RATE_D2) qual = (phase[0] == 1'b0);
      else                 qual = (phase == '0);
    end else begin
      if (rate == RATE_D2) qual = (phase[0] == match_phase[0]);
      else                 qual = (phase == match_phase);
    end
  end

  always_comb begin
    wrap  = (pre_q == pre_last(rate));
    tick  = qual && !clr && wrap;
    pre_d = pre_q;
    if (clr)       pre_d = '0;
    else if (qual) pre_d = wrap ? '0 : pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign pre_o = pre_q;
endmodule

// File: rtl/dt_core.sv
module dt_core #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             reload,
  output logic             hi_o,
  output logic             lo_o
);
  logic             pwm_q, pwm_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             hi_q, hi_d;
  logic             lo_q, lo_d;

  always_comb begin
    reload = pwm_in ^ pwm_q;
    pwm_d  = pwm_in;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    if (reload) begin
      cnt_d = load_val;
      if (load_val == '0) begin
        busy_d = 1'b0;
        hi_d   = pwm_in;
        lo_d   = !pwm_in;
      end else begin
        busy_d = 1'b1;
        hi_d   = 1'b0;
        lo_d   = 1'b0;
      end
    end else if (busy_q && tick) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        hi_d   = pwm_q;
        lo_d   = !pwm_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q  <= 1'b0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
    end else begin
      pwm_q  <= pwm_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/dt_insert.sv
module dt_insert
  import dt_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [1:0]       cfg_psel,
  input  logic [1:0]       phase,
  input  logic [1:0]       match_phase,
  input  logic             base_fast,
  input  logic             pwm_in,
  output logic             gate_hi,
  output logic             gate_lo
);
  logic             srst_n;
  logic [CNT_W-1:0] dt_cnt;
  rate_e            dt_rate;
  logic             reload;
  logic             tick;
  logic             pre_clr;
  logic [PRE_W-1:0] pre_val;

  dt_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  dt_cfg_reg #(.CNT_W(CNT_W)) u_cfg (
    .clk     (clk),
    .rst_n   (srst_n),
    .we      (cfg_we),
    .cnt_in  (cfg_count),
    .rate_in (cfg_psel),
    .cnt_q   (dt_cnt),
    .rate_q  (dt_rate)
  );

  assign pre_clr = reload | cfg_we;

  dt_tick_gen u_tick (
    .clk         (clk),
    .rst_n       (srst_n),
    .phase       (phase),
    .match_phase (match_phase),
    .base_fast   (base_fast),
    .rate        (dt_rate),
    .clr         (pre_clr),
    .tick        (tick),
    .pre_o       (pre_val)
  );

  dt_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (srst_n),
    .pwm_in   (pwm_in),
    .load_val (dt_cnt),
    .tick     (tick),
    .reload   (reload),
    .hi_o     (gate_hi),
    .lo_o     (gate_lo)
  );
endmodule

// File: rtl/dt_insert_chk.sv
module dt_insert_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             srst_n,
  input logic             cfg_we,
  input logic [1:0]       phase,
  input logic [1:0]       match_phase,
  input logic             base_fast,
  input logic             pwm_in,
  input logic             gate_hi,
  input logic             gate_lo,
  input logic [CNT_W-1:0] dt_cnt,
  input logic [1:0]       dt_rate,
  input logic             reload,
  input logic             tick,
  input logic [1:0]       pre_val
);
  // R4
  a_r4_never_both: assert property (@(posedge clk) disable iff (!srst_n)
    !(gate_hi && gate_lo));
  // R3
  a_r3_rise_drops_lo: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(pwm_in) |=> !gate_lo);
  a_r3_fall_drops_hi: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(pwm_in) |=> !gate_hi);
  a_r3_hi_matches_input: assert property (@(posedge clk) disable iff (!srst_n)
    gate_hi |-> $past(pwm_in));
  a_r3_lo_matches_input: assert property (@(posedge clk) disable iff (!srst_n)
    gate_lo |-> !$past(pwm_in));
  // R5
  a_r5_zero_passes: assert property (@(posedge clk) disable iff (!srst_n)
    ($rose(pwm_in) && dt_cnt == '0) |=> gate_hi);
  // R6
  a_r6_slow_q1: assert property (@(posedge clk) disable iff (!srst_n)
    (!base_fast && dt_rate != 2'b00 && tick) |-> (phase == 2'd0));
  // R7
  a_r7_fast_pair: assert property (@(posedge clk) disable iff (!srst_n)
    (base_fast && dt_rate == 2'b00 && tick) |-> (phase[0] == match_phase[0]));
  // R8
  a_r8_fast_match: assert property (@(posedge clk) disable iff (!srst_n)
    (base_fast && dt_rate != 2'b00 && tick) |-> (phase == match_phase));
  // R10
  a_r10_pre_cleared: assert property (@(posedge clk) disable iff (!srst_n)
    (reload || cfg_we) |=> (pre_val == 2'd0));
endmodule

bind dt_insert dt_insert_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .srst_n      (srst_n),
  .cfg_we      (cfg_we),
  .phase       (phase),
  .match_phase (match_phase),
  .base_fast   (base_fast),
  .pwm_in      (pwm_in),
  .gate_hi     (gate_hi),
  .gate_lo     (gate_lo),
  .dt_cnt      (dt_cnt),
  .dt_rate     (dt_rate),
  .reload      (reload),
  .tick        (tick),
  .pre_val     (pre_val)
);

// File: tb/sim_dt_insert.sv
`timescale 1ns/1ps
module sim_dt_insert;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_count = '0;
  logic [1:0] cfg_psel = '0;
  logic [1:0] ph = '0;
  logic [1:0] match_phase = '0;
  logic       base_fast = 1'b0;
  logic       pwm_in = 1'b0;
  logic       gate_hi;
  logic       gate_lo;

  int checks = 0;
  int fails = 0;
  int cur_n = 0;
  int cur_ps = 0;

  always #4 clk = ~clk;
  always @(negedge clk) ph <= ph + 2'd1;

  dt_insert u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_count(cfg_count),
    .cfg_psel(cfg_psel), .phase(ph), .match_phase(match_phase),
    .base_fast(base_fast), .pwm_in(pwm_in), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycles after the reload edge until the delayed output turns on
  function automatic int predict(input int s, input int n, input int ps, input bit fast, input int mph);
    int pre = 0;
    int c = n;
    int ratio = (ps == 3) ? 4 : (ps == 2) ? 2 : 1;
    if (n == 0) return 0;
    for (int k = 1; k < 5000; k++) begin
      int p = (s + k) % 4;
      bit q;
      if (fast) q = (ps == 0) ? ((p % 2) == (mph % 2)) : (p == mph);
      else      q = (ps == 0) ? ((p % 2) == 0) : (p == 0);
      if (q) begin
        pre++;
        if (pre == ratio) begin
          pre = 0;
          c--;
          if (c == 0) return k;
        end
      end
    end
    return -1;
  endfunction

  task automatic set_cfg(input int n, input int ps);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_count = 6'(n); cfg_psel = 2'(ps);
    @(negedge clk); #1;
    cfg_we = 1'b0;
    cur_n = n; cur_ps = ps;
    repeat (2) @(negedge clk);
  endtask

  task automatic drive_edge(input bit v, output int s);
    @(negedge clk); #1;
    pwm_in = v;
    s = int'(ph);
  endtask

  // observe from the reload edge on; returns after delayed output turns on
  task automatic measure(input bit v, input int expk, input string req);
    int kk = 0;
    @(posedge clk); #2;
    check((v ? gate_lo : gate_hi) == 1'b0, {req, " R3 off-side drops"}, v ? gate_lo : gate_hi, 0);
    if (expk == 0) begin
      check((v ? gate_hi : gate_lo) == 1'b1, {req, " R5 immediate"}, v ? gate_hi : gate_lo, 1);
      return;
    end
    check((v ? gate_hi : gate_lo) == 1'b0, {req, " R3 held off"}, v ? gate_hi : gate_lo, 0);
    for (int i = 1; i < 5000; i++) begin
      @(posedge clk); #2;
      if (gate_hi && gate_lo) check(1'b0, {req, " R4 overlap"}, 1, 0);
      if ((v ? gate_hi : gate_lo) == 1'b1) begin kk = i; break; end
    end
    check(kk == expk, {req, " delay"}, kk, expk);
  endtask

  task automatic run_pair(input string req);
    int s;
    drive_edge(1'b1, s);
    measure(1'b1, predict(s, cur_n, cur_ps, base_fast, int'(match_phase)), req);
    repeat (3) @(negedge clk);
    drive_edge(1'b0, s);
    measure(1'b0, predict(s, cur_n, cur_ps, base_fast, int'(match_phase)), req);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    #2;
    check(gate_hi == 1'b0 && gate_lo == 1'b0, "R1 outputs low in reset", {gate_hi, gate_lo}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(gate_hi == 1'b0 && gate_lo == 1'b0, "R1 outputs low after reset", {gate_hi, gate_lo}, 0);
  endtask

  task automatic t_zero_cfg_after_reset;
    int s;
    // stored count is zero after reset: first edge passes at once
    cur_n = 0; cur_ps = 0;
    drive_edge(1'b1, s);
    measure(1'b1, 0, "R1 cleared count");
    repeat (2) @(negedge clk);
    drive_edge(1'b0, s);
    measure(1'b0, 0, "R5 zero count fall");
    repeat (2) @(negedge clk);
  endtask

  task automatic t_restart;
    int s;
    base_fast = 1'b0;
    set_cfg(6, 1);
    drive_edge(1'b1, s);
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #2;
      check(gate_hi == 1'b0, "R11 hi held", gate_hi, 0);
    end
    drive_edge(1'b0, s);
    measure(1'b0, predict(s, 6, 1, 1'b0, int'(match_phase)), "R11 restart");
    check(gate_hi == 1'b0, "R11 abandoned side off", gate_hi, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_cfg_clear;
    int s, s6, kk, expk;
    kk = 0;
    base_fast = 1'b1; match_phase = 2'd0;
    set_cfg(1, 3);
    drive_edge(1'b1, s);
    @(posedge clk); #2;
    for (int i = 1; i < 2000; i++) begin
      @(posedge clk); #2;
      if (i == 5) begin
        cfg_we = 1'b1; s6 = (s + 6) % 4;
      end else if (i == 6) cfg_we = 1'b0;
      if (gate_hi) begin kk = i; break; end
    end
    cfg_we = 1'b0;
    expk = 6 + predict(s6, 1, 3, 1'b1, 0);
    check(kk == expk, "R10 config write clears prescaler", kk, expk);
    drive_edge(1'b0, s);
    measure(1'b0, predict(s, 1, 3, 1'b1, 0), "R10 reload");
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_zero_cfg_after_reset();
    base_fast = 1'b0; set_cfg(3, 1); run_pair("R6 R2 slow div4");
    base_fast = 1'b0; set_cfg(2, 3); run_pair("R9 slow div16");
    base_fast = 1'b0; set_cfg(5, 0); run_pair("R6 slow div2 pair");
    base_fast = 1'b1; match_phase = 2'd1; set_cfg(4, 0); run_pair("R7 fast odd pair");
    base_fast = 1'b1; match_phase = 2'd2; set_cfg(4, 0); run_pair("R7 fast even pair");
    base_fast = 1'b1; match_phase = 2'd2; set_cfg(3, 2); run_pair("R8 R9 fast div8");
    base_fast = 1'b1; match_phase = 2'd3; set_cfg(2, 1); run_pair("R8 fast div4");
    base_fast = 1'b0; set_cfg(0, 2); run_pair("R5 zero count");
    t_restart();
    t_cfg_clear();
    base_fast = 1'b0; set_cfg(63, 3); run_pair("R12 full count");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule